// File: doc/BRIEF.md
# Write-only I2C control target

This block is a receive-only target on a two-wire I2C-compatible control bus. It turns bus traffic into plain byte-wide register writes for the logic behind it. SCL and SDA are brought into the system clock domain through synchronizers. The block watches for start and stop conditions and assembles the first byte after a start as an 8-bit chip address.

That address byte is compared in full, direction bit included, against a fixed pattern. One bit of the pattern is set by an address-select pin, so two copies can share one bus. On a match the target acknowledges. It then takes any number of data bytes, acknowledging each one and handing each one to the fabric as a single write strobe. On a mismatch the target stays silent until the bus shows a new start condition.

The SDA output is modelled as an open-drain enable: when the enable is high, the pad pulls the line low. Read transfers, clock stretching, 10-bit and general-call addressing are not handled.

Top module: `i2c_write_target`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `sda_oe` and `wr_valid` are 0.
- R2: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high. Every byte is captured on SCL rising edges, most significant bit first.
- R3: The address byte is accepted only if it equals 8'hF8 when `addr_sel` is 0, or 8'hFA when `addr_sel` is 1. Bit 1 follows the pin and bit 0 must be 0, so 8'hF9 is refused. On a match, `sda_oe` is 1 throughout the high phase of the ninth SCL clock.
- R4: After a refused address, no acknowledge is driven and no write is issued for any byte until the next start.
- R5: After an accepted address, every complete data byte is acknowledged in its ninth clock. Any number of bytes may follow one another in the same transfer.
- R6: Each complete data byte produces exactly one `wr_valid` pulse, one system clock long, with the byte on `wr_data`. The pulse follows the SCL rise that captured the byte's eighth bit.
- R7: A start seen in any state, including part way through a byte, discards the partial byte and restarts address reception.
- R8: A stop returns the target to idle and discards a partial byte. Bytes clocked after a stop and before a new start are neither acknowledged nor written.
- R9: `sda_oe` changes value only while SCL is low. Reset and the handling of a start or stop are the exceptions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Selects bit 1 of the accepted address byte |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_data | output | 8 | Received data byte, valid with `wr_valid` |

## Verification
The hardest cases to reach from the ports are a start condition that arrives part way through a byte, and a stop that cuts a data byte short. A normal bus controller never produces either one. The bench bus model therefore clocks only a few bits of a byte and then builds a repeated start or a stop by hand. It then checks that the partial byte never shows up as a write, and that the next address is still recognised. Refused addresses, including the one with the direction bit set, are each followed by data bytes. This proves that the skip state stays quiet on both the acknowledge and the write strobe.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_DATA,
    PH_DATA_ACK,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic scl_lvl;
    logic sda_lvl;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync
  import i2cw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);

  localparam int NLINES = 2;   // index 0 = SCL, index 1 = SDA

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  // One synchronizer chain per bus line; an idle bus is high.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= lvl;
  end

  // SDA edges are qualified by SCL held high in both samples.
  always_comb begin
    ev.scl_lvl  = lvl[0];
    ev.sda_lvl  = lvl[1];
    ev.scl_rise = lvl[0] & ~prv[0];
    ev.scl_fall = ~lvl[0] & prv[0];
    ev.start    = prv[1] & ~lvl[1] & lvl[0] & prv[0];
    ev.stop     = ~prv[1] & lvl[1] & lvl[0] & prv[0];
  end

endmodule

// File: rtl/i2cw_addr_match.sv
module i2cw_addr_match #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   BASE    = 8'hF8,
  parameter int             SEL_POS = 1
) (
  input  logic [W-1:0] cand,
  input  logic         sel,
  output logic         hit
);

  logic [W-1:0] want;

  always_comb begin
    want          = BASE;
    want[SEL_POS] = sel;
  end

  assign hit = (cand == want);

endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
  import i2cw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_ev_t           ev,
  input  logic              hit,
  output logic [DATA_W-1:0] cand,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);

  localparam int                CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

  phase_t            ph;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              oe_q;
  logic              wv_q;
  logic [DATA_W-1:0] wd_q;

  // Byte as it stands once the current SDA sample is shifted in.
  assign cand = {shreg[DATA_W-2:0], ev.sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      oe_q   <= 1'b0;
      wv_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      wv_q <= 1'b0;
      if (ev.start) begin
        ph     <= PH_ADDR;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (ev.stop) begin
        ph     <= PH_IDLE;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else begin
        unique case (ph)
          PH_ADDR, PH_DATA: begin
            if (ev.scl_rise) begin
              shreg <= cand;
              if (bitcnt == LAST) begin
                bitcnt <= '0;
                if (ph == PH_ADDR) begin
                  ph <= hit ? PH_ADDR_ACK : PH_SKIP;
                end else begin
                  ph   <= PH_DATA_ACK;
                  wv_q <= 1'b1;
                  wd_q <= cand;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          PH_ADDR_ACK, PH_DATA_ACK: begin
            // First SCL fall: pull low; second fall: release, next byte.
            if (ev.scl_fall) begin
              if (!oe_q) begin
                oe_q <= 1'b1;
              end else begin
                oe_q <= 1'b0;
                ph   <= PH_DATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe_q;
  assign wr_valid = wv_q;
  assign wr_data  = wd_q;

  // R5: the line is only pulled during an acknowledge phase
  p_oe_in_ack_r5: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (ph == PH_ADDR_ACK || ph == PH_DATA_ACK));

  // R6: the write strobe is never wider than one cycle
  p_wr_single_r6: assert property (@(posedge clk) disable iff (rst)
    wv_q |=> !wv_q);

  // R4: a refused transfer drives nothing
  p_skip_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SKIP) |-> (!oe_q && !wv_q));

  // R3: entering the address acknowledge requires a comparator hit
  p_ack_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ADDR_ACK && $past(ph) == PH_ADDR) |-> $past(hit));

  // R9: enable toggles only with SCL low, apart from start/stop handling
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    ((oe_q != $past(oe_q)) && !$past(ev.start) && !$past(ev.stop))
      |-> !$past(ev.scl_lvl));

endmodule

// File: rtl/i2c_write_target.sv
module i2c_write_target
  import i2cw_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  ADDR_BASE   = 8'hF8,
  parameter int          SEL_POS     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);

  bus_ev_t           ev;
  logic [DATA_W-1:0] cand;
  logic              hit;

  i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  i2cw_addr_match #(.W(DATA_W), .BASE(ADDR_BASE), .SEL_POS(SEL_POS)) u_match (
    .cand (cand),
    .sel  (addr_sel),
    .hit  (hit)
  );

  i2cw_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .hit      (hit),
    .cand     (cand),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_data  (wr_data)
  );

  // R6: a write strobe always follows a captured SCL rise
  p_wr_after_rise_r6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(ev.scl_rise));

  // R2: start and stop never coincide with an SCL edge
  p_cond_no_scl_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (ev.start || ev.stop) |-> !(ev.scl_rise || ev.scl_fall));

endmodule

// File: tb/sim_i2c_write_target.sv
module sim_i2c_write_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;   // quarter SCL period in system clocks
  localparam int NVEC       = 6;

  // {sel, addr[7:0], nbytes[1:0], d0, d1, d2, expect_ack}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 8'hF8, 2'd1, 8'h5A, 8'h00, 8'h00, 1'b1},
    {1'b1, 8'hFA, 2'd2, 8'h3C, 8'h81, 8'h00, 1'b1},
    {1'b0, 8'hFA, 2'd2, 8'h11, 8'h22, 8'h00, 1'b0},
    {1'b1, 8'hF8, 2'd1, 8'h77, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hF9, 2'd1, 8'h44, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hFA, 2'd3, 8'h00, 8'hFF, 8'hA5, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_oe;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] wlog [64];
  int   wcnt = 0;
  logic prev_wv = 1'b0;
  logic prev_oe = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_write_target u0 (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .addr_sel (addr_sel),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_data  (wr_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Write monitor (R6) and enable timing monitor (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) begin
        if (wcnt < 64) wlog[wcnt] = wr_data;
        wcnt++;
        chk(!prev_wv, "R6 strobe width", 32'(prev_wv), 32'd0);
      end
      if (sda_oe != prev_oe)
        chk(!scl_m, "R9 enable change with SCL high", 32'(scl_m), 32'd0);
    end
    prev_wv = wr_valid;
    prev_oe = sda_oe;
  end

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
    end
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    ack = ~sda_line;
    wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [35:0] v;
    int         base;
    int         nb;

    wait_clk(4);
    chk(sda_oe == 1'b0, "R1 oe in reset", 32'(sda_oe), 32'd0);
    chk(wr_valid == 1'b0, "R1 strobe in reset", 32'(wr_valid), 32'd0);
    rst = 1'b0;
    wait_clk(1);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 after release",
        32'({sda_oe, wr_valid}), 32'd0);
    wait_clk(5);

    // Table-driven transfers: R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      v        = VEC[k];
      addr_sel = v[35];
      nb       = int'(v[26:25]);
      base     = wcnt;
      wait_clk(Q);
      bus_start();
      bus_byte(v[34:27], ack);
      chk(ack == v[0], "R3 R4 address acknowledge", 32'(ack), 32'(v[0]));
      for (int j = 0; j < nb; j++) begin
        bus_byte(v[24-8*j -: 8], ack);
        chk(ack == v[0], "R5 R4 data acknowledge", 32'(ack), 32'(v[0]));
      end
      bus_stop();
      wait_clk(Q);
      chk(wcnt - base == (v[0] ? nb : 0), "R6 R4 write count",
          32'(wcnt - base), 32'(v[0] ? nb : 0));
      if (v[0]) begin
        for (int j = 0; j < nb; j++)
          chk(wlog[base+j] == v[24-8*j -: 8], "R2 R6 write data msb first",
              32'(wlog[base+j]), 32'(v[24-8*j -: 8]));
      end
    end

    // R7: start part way through a data byte
    addr_sel = 1'b0;
    base = wcnt;
    bus_start();
    bus_byte(8'hF8, ack);
    chk(ack, "R7 first address", 32'(ack), 32'd1);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start();
    bus_byte(8'hF8, ack);
    chk(ack, "R7 address after mid-byte start", 32'(ack), 32'd1);
    bus_byte(8'hC3, ack);
    bus_stop();
    wait_clk(Q);
    chk(wcnt - base == 1, "R7 partial byte dropped", 32'(wcnt - base), 32'd1);
    chk(wlog[base] == 8'hC3, "R7 data after restart", 32'(wlog[base]), 32'hC3);

    // R7 R4: refused address, then repeated start without a stop
    base = wcnt;
    bus_start();
    bus_byte(8'hF9, ack);
    chk(!ack, "R4 refused read-direction byte", 32'(ack), 32'd0);
    bus_byte(8'hF8, ack);
    chk(!ack, "R4 skip state silent", 32'(ack), 32'd0);
    bus_start();
    bus_byte(8'hF8, ack);
    chk(ack, "R7 repeated start accepted", 32'(ack), 32'd1);
    bus_byte(8'h96, ack);
    bus_stop();
    wait_clk(Q);
    chk(wcnt - base == 1, "R7 R4 write count", 32'(wcnt - base), 32'd1);
    chk(wlog[base] == 8'h96, "R7 data after repeated start", 32'(wlog[base]), 32'h96);

    // R8: stop cuts a data byte short, then bytes with no start
    addr_sel = 1'b1;
    base = wcnt;
    bus_start();
    bus_byte(8'hFA, ack);
    bus_byte(8'h12, ack);
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_stop();
    wait_clk(Q);
    chk(wcnt - base == 1, "R8 partial byte dropped on stop", 32'(wcnt - base), 32'd1);
    scl_m = 1'b0; wait_clk(Q);
    bus_byte(8'hFA, ack);
    chk(!ack, "R8 no acknowledge without start", 32'(ack), 32'd0);
    bus_byte(8'h34, ack);
    chk(!ack, "R8 idle data ignored", 32'(ack), 32'd0);
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(2*Q);
    chk(wcnt - base == 1, "R8 no write while idle", 32'(wcnt - base), 32'd1);

    done = 1'b1;
    report();
    $finish;
  end

endmodule